// File: doc/BRIEF.md
# Millisecond Real-Time Counter with Seconds Snapshot

This block keeps wall-clock time as a seconds count and a milliseconds count. A single-cycle 1 kHz enable, synchronous to the block clock, advances the millisecond count. When it passes the last millisecond of a second, it returns to zero and seconds increments in the same cycle. The counter never stops. It has no suspend or gating input, so time keeps advancing while the rest of the system sleeps.

Software reads the block over a simple 32-bit register bus, and read data returns one cycle after the request. A read of the milliseconds register also copies the seconds count from that same cycle into a snapshot register. Software reads milliseconds first and then the snapshot. It forms the time as snapshot × 1000 + milliseconds, as a wrapping 32-bit value. This pair is never torn, even if a rollover falls between the two bus reads. A write to the seconds offset presets seconds and restarts the millisecond count.

Top module: `msrtc_top`

## Requirements
- R1: After a synchronous active-high reset, seconds, milliseconds and the snapshot all read as zero, and the read-valid output is low.
- R2: Each cycle with the tick input high advances milliseconds by one. A cycle without a tick (and without a preset write) leaves both counts unchanged.
- R3: Milliseconds stays in the range 0 to 999. A tick while it holds 999 sets it to 0 and increments seconds by one in the same clock edge.
- R4: A read request (valid high, write low) produces read-valid high with its data exactly one cycle later. In any other cycle read-valid is low.
- R5: A read of offset 0x10 returns the milliseconds value of the request cycle, zero-extended. In the same edge it loads the snapshot with the seconds value of that cycle, so the pair is consistent even when a tick rolls seconds over in that cycle.
- R6: A read of offset 0x0C returns the snapshot. The snapshot changes only on a read of offset 0x10.
- R7: A write of offset 0x08 sets seconds to the write data and milliseconds to 0. When a tick arrives in the same cycle, the write wins.
- R8: Writes to offsets 0x0C and 0x10 change neither count nor the snapshot.
- R9: A read of offset 0x08 returns the live seconds count. Reads of any other unmapped offset return zero.
- R10: Seconds wraps from 0xFFFFFFFF to 0 on a rollover.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Single-cycle 1 kHz advance enable |
| req_valid_i | input | 1 | Bus request strobe |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 8 | Byte offset of the register |
| req_wdata_i | input | 32 | Write data |
| rd_valid_o | output | 1 | Read data valid, one cycle after a read |
| rd_data_o | output | 32 | Read data |

## Verification
The hardest case is a milliseconds read issued in the very cycle a tick rolls 999 over to 0. A design that snapshots post-edge seconds would report a time nearly one second ahead, and one that returns post-edge milliseconds would pair 0 with the old second. The bench also presets seconds to all ones and rolls it over, to expose a design that saturates or leaves stale bits after the wrap. It issues a preset in the same cycle as a tick, which catches a design that gives the tick priority and leaves milliseconds at 1. Writes to the read-only offsets are followed by reads of both counts and the snapshot, and so are reads of seconds and unmapped offsets; a decoder that aliases them would corrupt one of those values.

// File: rtl/msrtc_pkg.sv
package msrtc_pkg;

    localparam int unsigned BUS_DW = 32;
    localparam int unsigned BUS_AW = 8;

    localparam logic [BUS_AW-1:0] OFS_SECONDS  = 8'h08;
    localparam logic [BUS_AW-1:0] OFS_SNAPSHOT = 8'h0C;
    localparam logic [BUS_AW-1:0] OFS_MILLIS   = 8'h10;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_SECONDS,
        SEL_SNAPSHOT,
        SEL_MILLIS
    } reg_sel_t;

    typedef struct packed {
        logic              valid;
        logic              write;
        logic [BUS_AW-1:0] addr;
        logic [BUS_DW-1:0] wdata;
    } bus_req_t;

    function automatic reg_sel_t decode_offset(input logic [BUS_AW-1:0] addr);
        reg_sel_t sel;
        case (addr)
            OFS_SECONDS:  sel = SEL_SECONDS;
            OFS_SNAPSHOT: sel = SEL_SNAPSHOT;
            OFS_MILLIS:   sel = SEL_MILLIS;
            default:      sel = SEL_NONE;
        endcase
        return sel;
    endfunction

endpackage

// File: rtl/msrtc_counter.sv
module msrtc_counter #(
    parameter int unsigned MS_PER_SEC = 1000,
    parameter int unsigned SEC_W      = 32,
    localparam int unsigned MS_W      = $clog2(MS_PER_SEC)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             preset_en_i,
    input  logic [SEC_W-1:0] preset_val_i,
    output logic [SEC_W-1:0] sec_o,
    output logic [MS_W-1:0]  ms_o
);
    localparam logic [MS_W-1:0] MS_LAST = MS_W'(MS_PER_SEC - 1);

    logic [SEC_W-1:0] sec_q;
    logic [MS_W-1:0]  ms_q;
    logic             ms_last;

    assign ms_last = (ms_q == MS_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            sec_q <= '0;
            ms_q  <= '0;
        end else if (preset_en_i) begin
            sec_q <= preset_val_i;
            ms_q  <= '0;
        end else if (tick_i) begin
            if (ms_last) begin
                ms_q  <= '0;
                sec_q <= sec_q + 1'b1;
            end else begin
                ms_q <= ms_q + 1'b1;
            end
        end
    end

    assign sec_o = sec_q;
    assign ms_o  = ms_q;

    assert_ms_range_R3: assert property (@(posedge clk) disable iff (rst)
        ms_o < MS_W'(MS_PER_SEC));

    assert_tick_step_R2: assert property (@(posedge clk) disable iff (rst)
        (tick_i && !preset_en_i && ms_o != MS_LAST) |=>
        (ms_o == $past(ms_o) + 1'b1) && $stable(sec_o));

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!tick_i && !preset_en_i) |=> $stable(ms_o) && $stable(sec_o));

    assert_rollover_R3: assert property (@(posedge clk) disable iff (rst)
        (tick_i && !preset_en_i && ms_o == MS_LAST) |=>
        (ms_o == '0) && (sec_o == $past(sec_o) + 1'b1));

    assert_preset_wins_R7: assert property (@(posedge clk) disable iff (rst)
        preset_en_i |=> (sec_o == $past(preset_val_i)) && (ms_o == '0));

endmodule

// File: rtl/msrtc_snapshot.sv
module msrtc_snapshot #(
    parameter int unsigned SEC_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [SEC_W-1:0] sec_i,
    output logic [SEC_W-1:0] shadow_o
);
    logic [SEC_W-1:0] shadow_q;

    always_ff @(posedge clk) begin
        if (rst)         shadow_q <= '0;
        else if (load_i) shadow_q <= sec_i;
    end

    assign shadow_o = shadow_q;

    assert_snap_load_R5: assert property (@(posedge clk) disable iff (rst)
        load_i |=> shadow_o == $past(sec_i));

    assert_snap_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> $stable(shadow_o));

endmodule

// File: rtl/msrtc_regif.sv
module msrtc_regif
    import msrtc_pkg::*;
#(
    parameter int unsigned SEC_W = 32,
    parameter int unsigned MS_W  = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_req_t          req_i,
    input  logic [SEC_W-1:0]  sec_i,
    input  logic [SEC_W-1:0]  shadow_i,
    input  logic [MS_W-1:0]   ms_i,
    output logic              preset_en_o,
    output logic [SEC_W-1:0]  preset_val_o,
    output logic              snap_en_o,
    output logic              rd_valid_o,
    output logic [BUS_DW-1:0] rd_data_o
);
    reg_sel_t          sel;
    logic              is_read;
    logic [BUS_DW-1:0] rd_mux;
    logic              rd_valid_q;
    logic [BUS_DW-1:0] rd_data_q;

    assign sel          = decode_offset(req_i.addr);
    assign is_read      = req_i.valid && !req_i.write;
    assign preset_en_o  = req_i.valid && req_i.write && (sel == SEL_SECONDS);
    assign preset_val_o = req_i.wdata[SEC_W-1:0];
    assign snap_en_o    = is_read && (sel == SEL_MILLIS);

    always_comb begin
        case (sel)
            SEL_SECONDS:  rd_mux = BUS_DW'(sec_i);
            SEL_SNAPSHOT: rd_mux = BUS_DW'(shadow_i);
            SEL_MILLIS:   rd_mux = BUS_DW'(ms_i);
            default:      rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid_q <= 1'b0;
            rd_data_q  <= '0;
        end else begin
            rd_valid_q <= is_read;
            rd_data_q  <= is_read ? rd_mux : '0;
        end
    end

    assign rd_valid_o = rd_valid_q;
    assign rd_data_o  = rd_data_q;

    assert_rd_latency_R4: assert property (@(posedge clk) disable iff (rst)
        req_i.valid && !req_i.write |=> rd_valid_o);

    assert_rd_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        !(req_i.valid && !req_i.write) |=> !rd_valid_o);

    assert_ms_readback_R5: assert property (@(posedge clk) disable iff (rst)
        snap_en_o |=> rd_data_o == BUS_DW'($past(ms_i)));

endmodule

// File: rtl/msrtc_top.sv
module msrtc_top
    import msrtc_pkg::*;
#(
    parameter int unsigned MS_PER_SEC = 1000,
    parameter int unsigned SEC_W      = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              req_valid_i,
    input  logic              req_write_i,
    input  logic [BUS_AW-1:0] req_addr_i,
    input  logic [BUS_DW-1:0] req_wdata_i,
    output logic              rd_valid_o,
    output logic [BUS_DW-1:0] rd_data_o
);
    localparam int unsigned MS_W = $clog2(MS_PER_SEC);

    bus_req_t         req;
    logic [SEC_W-1:0] sec;
    logic [SEC_W-1:0] shadow;
    logic [MS_W-1:0]  ms;
    logic             preset_en;
    logic [SEC_W-1:0] preset_val;
    logic             snap_en;

    assign req.valid = req_valid_i;
    assign req.write = req_write_i;
    assign req.addr  = req_addr_i;
    assign req.wdata = req_wdata_i;

    msrtc_counter #(.MS_PER_SEC(MS_PER_SEC), .SEC_W(SEC_W)) u_counter (
        .clk          (clk),
        .rst          (rst),
        .tick_i       (tick_i),
        .preset_en_i  (preset_en),
        .preset_val_i (preset_val),
        .sec_o        (sec),
        .ms_o         (ms)
    );

    msrtc_snapshot #(.SEC_W(SEC_W)) u_snapshot (
        .clk      (clk),
        .rst      (rst),
        .load_i   (snap_en),
        .sec_i    (sec),
        .shadow_o (shadow)
    );

    msrtc_regif #(.SEC_W(SEC_W), .MS_W(MS_W)) u_regif (
        .clk          (clk),
        .rst          (rst),
        .req_i        (req),
        .sec_i        (sec),
        .shadow_i     (shadow),
        .ms_i         (ms),
        .preset_en_o  (preset_en),
        .preset_val_o (preset_val),
        .snap_en_o    (snap_en),
        .rd_valid_o   (rd_valid_o),
        .rd_data_o    (rd_data_o)
    );

endmodule

// File: tb/msrtc_top_test.sv
module msrtc_top_test;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        rv = 1'b0;
    logic        rw = 1'b0;
    logic [7:0]  ra = '0;
    logic [31:0] wd = '0;
    logic        rd_valid;
    logic [31:0] rd_data;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    logic [31:0] m_sec = 0, m_shadow = 0;
    int unsigned m_ms = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    msrtc_top uut (
        .clk(clk), .rst(rst), .tick_i(tick),
        .req_valid_i(rv), .req_write_i(rw), .req_addr_i(ra), .req_wdata_i(wd),
        .rd_valid_o(rd_valid), .rd_data_o(rd_data)
    );

    function automatic logic [31:0] model_read(input logic [7:0] a);
        case (a)
            8'h08:   return m_sec;
            8'h0C:   return m_shadow;
            8'h10:   return 32'(m_ms);
            default: return 32'h0;
        endcase
    endfunction

    task automatic cyc(input bit tk, input bit v, input bit w,
                       input logic [7:0] a, input logic [31:0] d, input string req);
        logic [31:0] exp_d;
        bit exp_v;
        @(negedge clk);
        tick = tk; rv = v; rw = w; ra = a; wd = d;
        exp_v = v && !w;
        exp_d = exp_v ? model_read(a) : 32'h0;
        if (exp_v && a == 8'h10) m_shadow = m_sec;
        if (v && w && a == 8'h08) begin
            m_sec = d; m_ms = 0;
        end else if (tk) begin
            if (m_ms == 999) begin m_ms = 0; m_sec = m_sec + 1; end
            else m_ms = m_ms + 1;
        end
        @(posedge clk);
        #(CLK_PERIOD/4);
        tick = 0; rv = 0; rw = 0;
        vectors++;
        if (rd_valid !== exp_v || (exp_v && rd_data !== exp_d)) begin
            errors++;
            $display("FAIL %s addr=%h: got valid=%0b data=%h, expected valid=%0b data=%h",
                     req, a, rd_valid, rd_data, exp_v, exp_d);
        end
    endtask

    task automatic rd(input logic [7:0] a, input string req);
        cyc(0, 1, 0, a, 0, req);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) cyc(1, 0, 0, 0, 0, "R2");
    endtask

    initial begin
        void'($urandom(32'hC0FFEE));
        repeat (3) @(posedge clk);
        #(CLK_PERIOD/4);
        rst = 0;
        // R1: reset values
        rd(8'h10, "R1"); rd(8'h08, "R1"); rd(8'h0C, "R1");
        // R2: advance and hold
        ticks(5); cyc(0, 0, 0, 0, 0, "R2"); rd(8'h10, "R2");
        // R9: unmapped offsets
        rd(8'h04, "R9"); rd(8'h14, "R9"); rd(8'h08, "R9");
        // R7: preset, then rollover read in the tick cycle (R3, R5)
        cyc(0, 1, 1, 8'h08, 32'd5, "R7");
        ticks(999);
        rd(8'h10, "R5");
        cyc(1, 1, 0, 8'h10, 0, "R5");
        rd(8'h0C, "R5"); rd(8'h08, "R3"); rd(8'h10, "R3");
        // R6: seconds/unmapped reads leave snapshot alone
        ticks(3); rd(8'h08, "R6"); rd(8'h00, "R6"); rd(8'h0C, "R6");
        // R8: writes to read-only offsets
        cyc(0, 1, 1, 8'h0C, 32'hDEADBEEF, "R8");
        cyc(0, 1, 1, 8'h10, 32'h00000123, "R8");
        rd(8'h0C, "R8"); rd(8'h08, "R8"); rd(8'h10, "R8");
        // R7: preset wins over same-cycle tick
        ticks(7);
        cyc(1, 1, 1, 8'h08, 32'd77, "R7");
        rd(8'h10, "R7"); rd(8'h08, "R7");
        // R10: seconds wrap
        cyc(0, 1, 1, 8'h08, 32'hFFFF_FFFF, "R10");
        ticks(999);
        cyc(1, 1, 0, 8'h10, 0, "R10");
        rd(8'h0C, "R10"); rd(8'h08, "R10");
        // R4: random mix
        for (int i = 0; i < 4000; i++) begin
            int unsigned r = $urandom % 100;
            int unsigned k = $urandom % 6;
            logic [7:0] a;
            case (k)
                0: a = 8'h08; 1: a = 8'h0C; 2, 3: a = 8'h10;
                4: a = 8'h04; default: a = 8'($urandom);
            endcase
            if (r < 3)
                cyc($urandom % 2 == 0, 1, 1, a,
                    ($urandom % 2 == 0) ? 32'hFFFF_FFF0 + ($urandom % 16) : $urandom, "R4");
            else
                cyc($urandom % 10 != 0, r < 40, 0, a, 0, "R4");
        end
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule